// File: doc/BRIEF.md
# Tile Coordinate Mapper for Tiled Contrast Equalization

This block sits at the front of a tiled, interpolating histogram equalizer. For every pixel coordinate pair it produces two kinds of tile addressing. The first is the tile whose histogram the pixel contributes to. This is a plain division of each coordinate by the tile size. The second is the pair of neighbouring tiles on each axis whose mapping tables get blended for this pixel, together with the fixed-point weight of the far neighbour. The blending tiles are found on a grid shifted by half a tile. The near tile on an axis is the one whose centre lies at or before the pixel. The weight is the distance past that centre, divided by the tile size.

Along the image border there is no second tile centre to blend toward. Pixels closer to the edge than half a tile raise a skip flag for that axis. When a skip flag is set, both indices on that axis name the same edge tile and the weight is zero. A pixel in a corner raises both skip flags.

Coordinates enter on a valid/ready stream, and results leave one register stage later on a second valid/ready stream. A coordinate is taken when `in_valid` and `in_ready` are both high on a rising clock edge. A result is taken when `out_valid` and `out_ready` are both high. When the consumer holds `out_ready` low with a result pending, the result is held unchanged and `in_ready` drops. Back-pressure therefore reaches the producer in the same cycle. The image extent must be a whole multiple of the tile size, the tile size must be even, and every coordinate must lie inside the image.

Top module: `tile_coord_mapper`

## Requirements
- R1: The histogram tile indices are `hist_tx = x / TILE_W` and `hist_ty = y / TILE_H`, using truncating division.
- R2: When `TILE_W/2 <= x < IMG_W - TILE_W/2`, the blend indices are `left = (x - TILE_W/2) / TILE_W` and `right = left + 1`. The weight is `wx = floor(((x - TILE_W/2) mod TILE_W) * 2^FRAC_BITS / TILE_W)`, and `skip_h = 0`. A weight of 0 selects only the left tile.
- R3: The vertical axis follows the same rules as R2, using y, TILE_H and IMG_H. It yields `top`, `bottom = top + 1`, `wy`, and `skip_v = 0` in the interior band.
- R4: When `x < TILE_W/2`, the outputs are `skip_h = 1`, `left = right = 0`, and `wx = 0`.
- R5: When `x >= IMG_W - TILE_W/2`, the outputs are `skip_h = 1`, `left = right = IMG_W/TILE_W - 1`, and `wx = 0`.
- R6: The top and bottom margins follow the same rules as R4 and R5 on the vertical axis. They set `skip_v = 1`, make `top = bottom` equal to the edge row, and give `wy = 0`.
- R7: A pixel that falls in both a horizontal margin and a vertical margin (a corner) has `skip_h = 1` and `skip_v = 1` together.
- R8: Each accepted coordinate yields exactly one result, and results keep the order of acceptance. The result is presented on `out_valid` on the clock edge after acceptance.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every result output holds its value on the next edge.
- R10: `in_ready` is low exactly when a result is pending and `out_ready` is low. Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coordinate pair offered |
| in_ready | output | 1 | Coordinate pair can be taken |
| in_x | input | clog2(IMG_W) | Pixel column |
| in_y | input | clog2(IMG_H) | Pixel row |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result |
| out_hist_tx | output | clog2(IMG_W/TILE_W) | Histogram tile column |
| out_hist_ty | output | clog2(IMG_H/TILE_H) | Histogram tile row |
| out_tile_left | output | clog2(IMG_W/TILE_W) | Near blend column |
| out_tile_right | output | clog2(IMG_W/TILE_W) | Far blend column |
| out_tile_top | output | clog2(IMG_H/TILE_H) | Near blend row |
| out_tile_bottom | output | clog2(IMG_H/TILE_H) | Far blend row |
| out_wx | output | FRAC_BITS | Horizontal weight of the far column |
| out_wy | output | FRAC_BITS | Vertical weight of the far row |
| out_skip_h | output | 1 | Horizontal blend bypassed |
| out_skip_v | output | 1 | Vertical blend bypassed |

## Verification
The bench sweeps every coordinate of a full frame. This covers the pixels sitting exactly on a tile centre, where the weight must fall back to zero and the near tile must advance. A design that rounds or shifts the centre by one would show a weight of one step at the wrong pixel or a stale near index. The half-tile boundaries at both image edges are checked on each axis. An off-by-one there would clear a skip flag and point the far index one tile past the grid. Checks in the corners catch a design that merges the two axes' flags. Irregular consumer stalls are combined with gaps in the input. A register that loaded during a stall would overwrite a held result or duplicate a result, and the ordered scoreboard would report it.

// File: rtl/tile_map_pkg.sv
package tile_map_pkg;

  typedef enum logic [1:0] {
    ZONE_LOW  = 2'd0,
    ZONE_MID  = 2'd1,
    ZONE_HIGH = 2'd2
  } axis_zone_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tile_axis_map.sv
module tile_axis_map
  import tile_map_pkg::*;
#(
  parameter int EXTENT    = 64,
  parameter int TILE      = 16,
  parameter int FRAC_BITS = 6
) (
  input  logic [idx_bits(EXTENT)-1:0]      coord_i,
  output logic [idx_bits(EXTENT/TILE)-1:0] hist_o,
  output logic [idx_bits(EXTENT/TILE)-1:0] near_o,
  output logic [idx_bits(EXTENT/TILE)-1:0] far_o,
  output logic [FRAC_BITS-1:0]             frac_o,
  output axis_zone_e                       zone_o
);

  localparam int unsigned NT   = EXTENT / TILE;
  localparam int          IW   = idx_bits(EXTENT / TILE);
  localparam int unsigned HALF = TILE / 2;
  localparam int unsigned TU   = TILE;
  localparam int unsigned LAST = NT - 1;

  int unsigned c_u;
  int unsigned shifted;
  int unsigned near_u;
  int unsigned rem_u;
  int unsigned scaled;

  always_comb begin
    c_u     = 32'(coord_i);
    shifted = c_u - HALF;
    near_u  = shifted / TU;
    rem_u   = shifted - near_u * TU;
    scaled  = (rem_u << FRAC_BITS) / TU;
    hist_o  = IW'(c_u / TU);
    if (c_u < HALF) begin
      zone_o = ZONE_LOW;
      near_o = '0;
      far_o  = '0;
      frac_o = '0;
    end else if (near_u >= LAST) begin
      zone_o = ZONE_HIGH;
      near_o = IW'(LAST);
      far_o  = IW'(LAST);
      frac_o = '0;
    end else begin
      zone_o = ZONE_MID;
      near_o = IW'(near_u);
      far_o  = IW'(near_u + 1);
      frac_o = FRAC_BITS'(scaled);
    end
  end

endmodule

// File: rtl/tile_out_stage.sv
module tile_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic load;

  assign up_ready = !dn_valid || dn_ready;
  assign load     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else begin
      if (up_ready) dn_valid <= up_valid;
      if (load)     dn_data  <= up_data;
    end
  end

endmodule

// File: rtl/tile_coord_mapper.sv
module tile_coord_mapper
  import tile_map_pkg::*;
#(
  parameter int IMG_W     = 64,
  parameter int IMG_H     = 48,
  parameter int TILE_W    = 16,
  parameter int TILE_H    = 16,
  parameter int FRAC_BITS = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [idx_bits(IMG_W)-1:0]          in_x,
  input  logic [idx_bits(IMG_H)-1:0]          in_y,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [idx_bits(IMG_W/TILE_W)-1:0]   out_hist_tx,
  output logic [idx_bits(IMG_H/TILE_H)-1:0]   out_hist_ty,
  output logic [idx_bits(IMG_W/TILE_W)-1:0]   out_tile_left,
  output logic [idx_bits(IMG_W/TILE_W)-1:0]   out_tile_right,
  output logic [idx_bits(IMG_H/TILE_H)-1:0]   out_tile_top,
  output logic [idx_bits(IMG_H/TILE_H)-1:0]   out_tile_bottom,
  output logic [FRAC_BITS-1:0]                out_wx,
  output logic [FRAC_BITS-1:0]                out_wy,
  output logic                                out_skip_h,
  output logic                                out_skip_v
);

  localparam int TXW = idx_bits(IMG_W / TILE_W);
  localparam int TYW = idx_bits(IMG_H / TILE_H);
  localparam int DW  = 3 * TXW + 3 * TYW + 2 * FRAC_BITS + 2;

  logic [TXW-1:0]       hx, lx, rx;
  logic [TYW-1:0]       hy, ty, by;
  logic [FRAC_BITS-1:0] fx, fy;
  axis_zone_e           zx, zy;
  logic [DW-1:0]        pack_d, pack_q;

  tile_axis_map #(.EXTENT(IMG_W), .TILE(TILE_W), .FRAC_BITS(FRAC_BITS)) u_axis_x (
    .coord_i(in_x), .hist_o(hx), .near_o(lx), .far_o(rx), .frac_o(fx), .zone_o(zx)
  );

  tile_axis_map #(.EXTENT(IMG_H), .TILE(TILE_H), .FRAC_BITS(FRAC_BITS)) u_axis_y (
    .coord_i(in_y), .hist_o(hy), .near_o(ty), .far_o(by), .frac_o(fy), .zone_o(zy)
  );

  assign pack_d = {hx, hy, lx, rx, ty, by, fx, fy,
                   (zx != ZONE_MID), (zy != ZONE_MID)};

  tile_out_stage #(.W(DW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(pack_d),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(pack_q)
  );

  assign {out_hist_tx, out_hist_ty, out_tile_left, out_tile_right,
          out_tile_top, out_tile_bottom, out_wx, out_wy,
          out_skip_h, out_skip_v} = pack_q;

endmodule

// File: rtl/tile_coord_mapper_chk.sv
module tile_coord_mapper_chk
  import tile_map_pkg::*;
#(
  parameter int IMG_W     = 64,
  parameter int IMG_H     = 48,
  parameter int TILE_W    = 16,
  parameter int TILE_H    = 16,
  parameter int FRAC_BITS = 6
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              in_valid,
  input logic                              in_ready,
  input logic                              out_valid,
  input logic                              out_ready,
  input logic [idx_bits(IMG_W/TILE_W)-1:0] out_hist_tx,
  input logic [idx_bits(IMG_H/TILE_H)-1:0] out_hist_ty,
  input logic [idx_bits(IMG_W/TILE_W)-1:0] out_tile_left,
  input logic [idx_bits(IMG_W/TILE_W)-1:0] out_tile_right,
  input logic [idx_bits(IMG_H/TILE_H)-1:0] out_tile_top,
  input logic [idx_bits(IMG_H/TILE_H)-1:0] out_tile_bottom,
  input logic [FRAC_BITS-1:0]              out_wx,
  input logic [FRAC_BITS-1:0]              out_wy,
  input logic                              out_skip_h,
  input logic                              out_skip_v
);

  assert_accept_then_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hist_tx) && $stable(out_hist_ty)
      && $stable(out_tile_left) && $stable(out_tile_right) && $stable(out_tile_top)
      && $stable(out_tile_bottom) && $stable(out_wx) && $stable(out_wy)
      && $stable(out_skip_h) && $stable(out_skip_v)));

  assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_interior_neighbours_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_skip_h) |-> (out_tile_right == out_tile_left + 1'b1));

  assert_interior_neighbours_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_skip_v) |-> (out_tile_bottom == out_tile_top + 1'b1));

  assert_margin_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_skip_h) |-> (out_wx == '0 && out_tile_left == out_tile_right));

  assert_margin_flat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_skip_v) |-> (out_wy == '0 && out_tile_top == out_tile_bottom));

  assert_hist_between_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_hist_tx == out_tile_left || out_hist_tx == out_tile_right)
      && (out_hist_ty == out_tile_top || out_hist_ty == out_tile_bottom)));

endmodule

bind tile_coord_mapper tile_coord_mapper_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .TILE_W(TILE_W), .TILE_H(TILE_H), .FRAC_BITS(FRAC_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_hist_tx(out_hist_tx), .out_hist_ty(out_hist_ty),
  .out_tile_left(out_tile_left), .out_tile_right(out_tile_right),
  .out_tile_top(out_tile_top), .out_tile_bottom(out_tile_bottom),
  .out_wx(out_wx), .out_wy(out_wy), .out_skip_h(out_skip_h), .out_skip_v(out_skip_v)
);

// File: tb/sim_tile_coord_mapper.sv
module sim_tile_coord_mapper;

  localparam int CLK_PERIOD = 10;
  localparam int IMG_W = 64;
  localparam int IMG_H = 48;
  localparam int TILE_W = 16;
  localparam int TILE_H = 16;
  localparam int FB = 6;
  localparam int TXW = 2;
  localparam int TYW = 2;

  typedef struct {
    int hx, hy, l, r, t, b, wx, wy, sh, sv;
    int x, y;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [5:0] in_x = '0;
  logic [5:0] in_y = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [TXW-1:0] out_hist_tx, out_tile_left, out_tile_right;
  logic [TYW-1:0] out_hist_ty, out_tile_top, out_tile_bottom;
  logic [FB-1:0] out_wx, out_wy;
  logic out_skip_h, out_skip_v;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stall_mode = 0;
  exp_t q[$];
  logic prev_stall = 1'b0;
  logic [3*TXW+3*TYW+2*FB+1:0] prev_snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_coord_mapper #(.IMG_W(IMG_W), .IMG_H(IMG_H), .TILE_W(TILE_W), .TILE_H(TILE_H),
                      .FRAC_BITS(FB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_hist_tx(out_hist_tx), .out_hist_ty(out_hist_ty),
    .out_tile_left(out_tile_left), .out_tile_right(out_tile_right),
    .out_tile_top(out_tile_top), .out_tile_bottom(out_tile_bottom),
    .out_wx(out_wx), .out_wy(out_wy), .out_skip_h(out_skip_h), .out_skip_v(out_skip_v)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference per axis, taken from R1..R6
  task automatic axis_model(input int c, input int ext, input int tile,
                            output int hist, output int lo, output int hi,
                            output int w, output int skip);
    int half;
    half = tile / 2;
    hist = c / tile;
    if (c < half) begin
      lo = 0; hi = 0; w = 0; skip = 1;
    end else if (c >= ext - half) begin
      lo = ext / tile - 1; hi = lo; w = 0; skip = 1;
    end else begin
      lo = (c - half) / tile; hi = lo + 1;
      w = (((c - half) % tile) * (1 << FB)) / tile; skip = 0;
    end
  endtask

  function automatic logic ready_pattern(input int n);
    case (stall_mode)
      1: return !((n % 7) == 3 || (n % 7) == 4);
      2: return ((n % 13) > 9);
      default: return 1'b1;
    endcase
  endfunction

  task automatic send(input int x, input int y);
    exp_t e;
    bit done;
    e.x = x; e.y = y;
    axis_model(x, IMG_W, TILE_W, e.hx, e.l, e.r, e.wx, e.sh);
    axis_model(y, IMG_H, TILE_H, e.hy, e.t, e.b, e.wy, e.sv);
    done = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      out_ready = ready_pattern(cyc);
      in_valid = 1'b1;
      in_x = 6'(x);
      in_y = 6'(y);
      #1;
      if (in_ready) begin
        q.push_back(e);
        done = 1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      out_ready = ready_pattern(cyc);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares each transferred result against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (prev_stall && out_valid)
          check("R9", "held result", (prev_snap == {out_hist_tx, out_hist_ty, out_tile_left,
                out_tile_right, out_tile_top, out_tile_bottom, out_wx, out_wy,
                out_skip_h, out_skip_v}) ? 1 : 0, 1);
        if (prev_stall) check("R9", "valid held", int'(out_valid), 1);
        if (out_valid && !out_ready) check("R10", "in_ready under stall", int'(in_ready), 0);
        prev_stall = out_valid && !out_ready;
        prev_snap = {out_hist_tx, out_hist_ty, out_tile_left, out_tile_right, out_tile_top,
                     out_tile_bottom, out_wx, out_wy, out_skip_h, out_skip_v};
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 unexpected result: actual 1 expected 0");
          end else begin
            exp_t e;
            string xr, yr;
            e = q.pop_front();
            xr = (e.sh == 0) ? "R2" : ((e.x < TILE_W/2) ? "R4" : "R5");
            yr = (e.sv == 0) ? "R3" : "R6";
            check("R1", "hist_tx", int'(out_hist_tx), e.hx);
            check("R1", "hist_ty", int'(out_hist_ty), e.hy);
            check(xr, "left", int'(out_tile_left), e.l);
            check(xr, "right", int'(out_tile_right), e.r);
            check(xr, "wx", int'(out_wx), e.wx);
            check(xr, "skip_h", int'(out_skip_h), e.sh);
            check(yr, "top", int'(out_tile_top), e.t);
            check(yr, "bottom", int'(out_tile_bottom), e.b);
            check(yr, "wy", int'(out_wy), e.wy);
            check(yr, "skip_v", int'(out_skip_v), e.sv);
            if (e.sh == 1 && e.sv == 1)
              check("R7", "corner flags", int'(out_skip_h & out_skip_v), 1);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "out_valid in reset", int'(out_valid), 0);
    check("R10", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    // Targeted corners and boundaries, consumer always ready
    stall_mode = 0;
    send(0, 0);
    send(7, 7);
    send(8, 8);
    send(9, 20);
    send(55, 39);
    send(56, 40);
    send(63, 47);
    send(0, 47);
    send(63, 0);
    send(24, 23);
    idle(3);
    // Single-cycle latency: accept then result on following edge
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_x = 6'd40; in_y = 6'd30;
    begin
      exp_t e;
      e.x = 40; e.y = 30;
      axis_model(40, IMG_W, TILE_W, e.hx, e.l, e.r, e.wx, e.sh);
      axis_model(30, IMG_H, TILE_H, e.hy, e.t, e.b, e.wy, e.sv);
      #1;
      if (in_ready) q.push_back(e);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R8", "valid one edge after accept", int'(out_valid), 1);
    idle(2);
    // Full frame sweep with short stalls and input gaps
    stall_mode = 1;
    for (int y = 0; y < IMG_H; y++) begin
      for (int x = 0; x < IMG_W; x++) begin
        send(x, y);
        if ((x % 11) == 5) idle(1);
      end
    end
    // Long stalls on a diagonal
    stall_mode = 2;
    for (int k = 0; k < IMG_H; k++) send((k * 5) % IMG_W, k);
    stall_mode = 0;
    idle(20);
    check("R8", "results outstanding", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule